// File: doc/BRIEF.md
# Protection Fault Sequencer

This block supervises a switching power controller. It decides, cycle by cycle, whether the gate driver may switch, based on the supply-rail comparator flags and on a set of protection flags. After the supply passes its on-level, a start hold gives the temperature sense node time to settle before switching starts. Faults fall into three groups:
- The discharge group waits for the supply rail to drain below its off-level.
- The recovery group waits out a long auto-recovery timer.
- The latch group, in the latched build only, holds the controller off until the supply collapses below the logic-reset level.

The analog comparators and the supply hiccup itself sit outside the block. Every long interval is a parameterized count of clock cycles. The raw line-low comparator output goes through an internal persistence filter before it counts as brown-out. The winding-short flag is qualified by the leading-edge blanking window, because the comparator that produces it is only meaningful there.

A build parameter selects the variant. In the auto-recovery build, over-temperature and both short faults use the recovery timer. In the latched build, these three faults lock the controller instead.

Top module: `prot_fault_seq`

## Requirements
- R1: After a synchronous active-low reset, `state_code` is 0 (reset state), `sw_en` is 0 and `fault_supply` is 0.
- R2: In the reset state, `vdd_above_on` moves the machine to the start-hold state (code 1). It stays there for START_HOLD_CYC+1 cycles and then enters run (code 2). `sw_en` is 1 only in run.
- R3: In run, thermal shutdown, a shorted sense pin or a filtered brown-out moves the machine to the discharge state (code 3), with switching off. The machine leaves for the reset state when `vdd_below_off` is 1.
- R4: Brown-out counts only once `line_low` has been 1 for BO_FILTER_CYC consecutive cycles. A shorter burst has no effect.
- R5: If the discharge was entered on brown-out, the machine returns to start hold as soon as the filtered brown-out clears. It does not wait for the supply to fall below the off-level.
- R6: Secondary over-voltage and supply over-voltage always move run to the recovery state (code 4), where `fault_supply` is 1. The machine leaves for start hold only after RECOVER_CYC cycles in that state, and only while `vdd_above_on` is 1.
- R7: In the latched build (LATCHED_BUILD=1), a winding short, an auxiliary short or over-temperature moves run to the latch state (code 5), where `fault_supply` is 1. `vdd_below_off` does not release it. Only `vdd_below_reset` does.
- R8: In the auto-recovery build, those three faults move run to the recovery state. If over-temperature was among the causes, leaving recovery also requires `temp_ok`.
- R9: `wind_short` is ignored unless `leb_active` is 1 in the same cycle.
- R10: When faults of several groups arrive in the same cycle, the latch group wins over the recovery group, and the recovery group wins over the discharge group.
- R11: `vdd_below_reset` forces the reset state on the next clock, whatever the current state.
- R12: `vdd_below_off` in start hold, or in run with no fault pending, returns the machine to the reset state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vdd_above_on | input | 1 | Supply above its start-up level |
| vdd_below_off | input | 1 | Supply below its stop level |
| vdd_below_reset | input | 1 | Supply below the logic-reset level |
| line_low | input | 1 | Raw line-below-threshold comparator |
| therm_sd | input | 1 | Die thermal shutdown |
| cs_short | input | 1 | Current-sense pin shorted |
| over_temp | input | 1 | External over-temperature |
| temp_ok | input | 1 | Temperature sense above its recovery level |
| sec_ovp | input | 1 | Secondary over-voltage |
| vdd_ovp | input | 1 | Supply over-voltage |
| wind_short | input | 1 | Winding or diode short comparator |
| leb_active | input | 1 | Leading-edge blanking window open |
| aux_short | input | 1 | Auxiliary winding or output short |
| sw_en | output | 1 | Switching permitted |
| fault_supply | output | 1 | Fault-mode start-up current selected |
| state_code | output | 3 | 0 reset, 1 start hold, 2 run, 3 discharge, 4 recovery, 5 latch |

## Verification
The interesting coincidence is a recovery-group fault and a discharge-group fault present in the same run cycle. This is provoked by raising thermal shutdown and secondary over-voltage together. A second case adds an auxiliary short to that pair, which brings in the latch group as well. The check is that the auto-recovery build lands in recovery (code 4), while the latched build lands in recovery for the first pair and in latch (code 5) once the auxiliary short joins. Both builds see identical stimulus side by side, so one sweep judges the group sorting of each variant against values computed from the group table.

// File: rtl/prot_seq_pkg.sv
// Shared types for the protection fault sequencer.
// Assumes: state codes are visible at the top port and must stay stable.
package prot_seq_pkg;

    typedef enum logic [2:0] {
        ST_RESET = 3'd0,
        ST_STOP  = 3'd1,
        ST_RUN   = 3'd2,
        ST_DISCH = 3'd3,
        ST_RECOV = 3'd4,
        ST_LATCH = 3'd5
    } seq_state_e;

    typedef enum logic [1:0] {
        REQ_NONE  = 2'd0,
        REQ_DISCH = 2'd1,
        REQ_RECOV = 2'd2,
        REQ_LATCH = 2'd3
    } fault_req_e;

    typedef struct packed {
        logic bo;
        logic tsd;
        logic cs_short;
        logic otp;
        logic sec_ovp;
        logic vdd_ovp;
        logic wind;
        logic aux;
    } fault_vec_t;

endpackage

// File: rtl/prot_cycle_timer.sv
// Saturating cycle counter: counts while run is high, clears when low.
// done is high once LIMIT consecutive run cycles have elapsed.
// Assumes: LIMIT >= 1.
module prot_cycle_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LIM_V = W'(LIMIT);

    logic [W-1:0] cnt;

    // Count up while enabled, saturate at the limit, clear when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (!run)         cnt <= '0;
        else if (cnt != LIM_V) cnt <= cnt + 1'b1;
    end

    assign done = (cnt == LIM_V);
endmodule

// File: rtl/prot_fault_classifier.sv
// Sorts qualified fault flags into one request by group priority:
// latch over recovery over discharge. LATCHED selects the build variant.
// Assumes: inputs are already filtered/qualified and synchronous.
module prot_fault_classifier
    import prot_seq_pkg::*;
#(
    parameter int LATCHED = 0
) (
    input  fault_vec_t fv,
    output fault_req_e req,
    output logic       otp_hit
);
    logic latch_grp;
    logic recov_extra;
    logic recov_grp;
    logic disch_grp;

    generate
        if (LATCHED != 0) begin : g_latched
            assign latch_grp   = fv.wind | fv.aux | fv.otp;
            assign recov_extra = 1'b0;
        end else begin : g_auto
            assign latch_grp   = 1'b0;
            assign recov_extra = fv.wind | fv.aux | fv.otp;
        end
    endgenerate

    assign recov_grp = fv.sec_ovp | fv.vdd_ovp | recov_extra;
    assign disch_grp = fv.bo | fv.tsd | fv.cs_short;
    assign otp_hit   = fv.otp;

    // Resolve group priority into a single request.
    always_comb begin
        if (latch_grp)      req = REQ_LATCH;
        else if (recov_grp) req = REQ_RECOV;
        else if (disch_grp) req = REQ_DISCH;
        else                req = REQ_NONE;
    end
endmodule

// File: rtl/prot_fault_seq.sv
// Protection fault sequencer top. Gates switching from supply flags and
// fault flags. Brown-out is persistence-filtered here; the winding short is
// qualified by the blanking window. Long intervals are cycle counts.
// Assumes: all inputs synchronous to clk; supply hiccup handled outside.
module prot_fault_seq
    import prot_seq_pkg::*;
#(
    parameter int LATCHED_BUILD  = 0,
    parameter int START_HOLD_CYC = 24000,
    parameter int RECOVER_CYC    = 400000000,
    parameter int BO_FILTER_CYC  = 5000000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vdd_above_on,
    input  logic       vdd_below_off,
    input  logic       vdd_below_reset,
    input  logic       line_low,
    input  logic       therm_sd,
    input  logic       cs_short,
    input  logic       over_temp,
    input  logic       temp_ok,
    input  logic       sec_ovp,
    input  logic       vdd_ovp,
    input  logic       wind_short,
    input  logic       leb_active,
    input  logic       aux_short,
    output logic       sw_en,
    output logic       fault_supply,
    output logic [2:0] state_code
);
    seq_state_e state, nxt;
    fault_vec_t fv;
    fault_req_e req;
    logic       otp_hit;
    logic       bo_flag;
    logic       hold_done;
    logic       rec_done;
    logic       otp_cause_q;
    logic       bo_cause_q;

    prot_cycle_timer #(.LIMIT(BO_FILTER_CYC)) u_bo_filt (
        .clk(clk), .rst_n(rst_n), .run(line_low), .done(bo_flag)
    );

    prot_cycle_timer #(.LIMIT(START_HOLD_CYC)) u_hold (
        .clk(clk), .rst_n(rst_n), .run(state == ST_STOP), .done(hold_done)
    );

    prot_cycle_timer #(.LIMIT(RECOVER_CYC)) u_recov (
        .clk(clk), .rst_n(rst_n), .run(state == ST_RECOV), .done(rec_done)
    );

    // Assemble the qualified fault vector.
    always_comb begin
        fv.bo       = bo_flag;
        fv.tsd      = therm_sd;
        fv.cs_short = cs_short;
        fv.otp      = over_temp;
        fv.sec_ovp  = sec_ovp;
        fv.vdd_ovp  = vdd_ovp;
        fv.wind     = wind_short & leb_active;
        fv.aux      = aux_short;
    end

    prot_fault_classifier #(.LATCHED(LATCHED_BUILD)) u_class (
        .fv(fv), .req(req), .otp_hit(otp_hit)
    );

    // Next-state selection; logic reset level overrides everything.
    always_comb begin
        nxt = state;
        if (vdd_below_reset) begin
            nxt = ST_RESET;
        end else begin
            case (state)
                ST_RESET: if (vdd_above_on) nxt = ST_STOP;
                ST_STOP: begin
                    if (vdd_below_off)  nxt = ST_RESET;
                    else if (hold_done) nxt = ST_RUN;
                end
                ST_RUN: begin
                    case (req)
                        REQ_LATCH: nxt = ST_LATCH;
                        REQ_RECOV: nxt = ST_RECOV;
                        REQ_DISCH: nxt = ST_DISCH;
                        default:   if (vdd_below_off) nxt = ST_RESET;
                    endcase
                end
                ST_DISCH: begin
                    if (vdd_below_off)               nxt = ST_RESET;
                    else if (bo_cause_q && !bo_flag) nxt = ST_STOP;
                end
                ST_RECOV: begin
                    if (rec_done && vdd_above_on && (!otp_cause_q || temp_ok))
                        nxt = ST_STOP;
                end
                ST_LATCH: nxt = ST_LATCH;
                default:  nxt = ST_RESET;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RESET;
        else        state <= nxt;
    end

    // Remember what caused entry to recovery or discharge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            otp_cause_q <= 1'b0;
            bo_cause_q  <= 1'b0;
        end else begin
            if (state == ST_RUN && nxt == ST_RECOV) otp_cause_q <= otp_hit;
            if (state == ST_RUN && nxt == ST_DISCH) bo_cause_q  <= bo_flag;
        end
    end

    assign sw_en        = (state == ST_RUN);
    assign fault_supply = (state == ST_RECOV) || (state == ST_LATCH);
    assign state_code   = state;
endmodule

// File: rtl/prot_fault_seq_chk.sv
// Temporal checks on the sequencer ports, bound to every instance.
// Assumes: state codes as listed in the brief.
module prot_fault_seq_chk #(
    parameter int LATCHED = 0
) (
    input logic       clk,
    input logic       rst_n,
    input logic       vdd_above_on,
    input logic       vdd_below_off,
    input logic       vdd_below_reset,
    input logic       sw_en,
    input logic [2:0] state_code
);
    // R2
    run_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_en) |-> $past(state_code) == 3'd1);

    // R6
    recov_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd4 && !vdd_above_on && !vdd_below_reset) |=> state_code == 3'd4);

    // R7
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd5 && !vdd_below_reset) |=> state_code == 3'd5);

    // R8
    no_latch_auto_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (LATCHED == 0) |-> state_code != 3'd5);

    // R11
    reset_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vdd_below_reset |=> state_code == 3'd0);

    // R12
    stop_uvlo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 3'd1 && vdd_below_off && !vdd_below_reset) |=> state_code == 3'd0);
endmodule

bind prot_fault_seq prot_fault_seq_chk #(.LATCHED(LATCHED_BUILD)) u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .vdd_above_on(vdd_above_on),
    .vdd_below_off(vdd_below_off),
    .vdd_below_reset(vdd_below_reset),
    .sw_en(sw_en),
    .state_code(state_code)
);

// File: tb/prot_fault_seq_tb_top.sv
// Drives an auto-recovery and a latched instance with identical stimulus
// and checks state codes against values derived from the requirements.
module prot_fault_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD = 5;
    localparam int REC  = 12;
    localparam int BO   = 6;
    localparam int WD_CYCLES = 20000;

    logic clk = 1'b0;
    logic rst_n;
    logic vdd_on, vdd_off, vdd_rst, line_low, tsd, cs_sh, otp, tok;
    logic sovp, vovp, wind, leb, aux;
    logic       a_en, a_flt, l_en, l_flt;
    logic [2:0] a_code, l_code;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prot_fault_seq #(.LATCHED_BUILD(0), .START_HOLD_CYC(HOLD),
                     .RECOVER_CYC(REC), .BO_FILTER_CYC(BO)) dut_i (
        .clk(clk), .rst_n(rst_n), .vdd_above_on(vdd_on), .vdd_below_off(vdd_off),
        .vdd_below_reset(vdd_rst), .line_low(line_low), .therm_sd(tsd),
        .cs_short(cs_sh), .over_temp(otp), .temp_ok(tok), .sec_ovp(sovp),
        .vdd_ovp(vovp), .wind_short(wind), .leb_active(leb), .aux_short(aux),
        .sw_en(a_en), .fault_supply(a_flt), .state_code(a_code));

    prot_fault_seq #(.LATCHED_BUILD(1), .START_HOLD_CYC(HOLD),
                     .RECOVER_CYC(REC), .BO_FILTER_CYC(BO)) dut_l (
        .clk(clk), .rst_n(rst_n), .vdd_above_on(vdd_on), .vdd_below_off(vdd_off),
        .vdd_below_reset(vdd_rst), .line_low(line_low), .therm_sd(tsd),
        .cs_short(cs_sh), .over_temp(otp), .temp_ok(tok), .sec_ovp(sovp),
        .vdd_ovp(vovp), .wind_short(wind), .leb_active(leb), .aux_short(aux),
        .sw_en(l_en), .fault_supply(l_flt), .state_code(l_code));

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_in;
        vdd_on = 0; vdd_off = 0; vdd_rst = 0; line_low = 0; tsd = 0; cs_sh = 0;
        otp = 0; tok = 0; sovp = 0; vovp = 0; wind = 0; leb = 0; aux = 0;
    endtask

    task automatic do_reset;
        clear_in();
        rst_n = 0;
        step(2);
        rst_n = 1;
    endtask

    // Reset, power up and reach run, checking start-hold timing.
    task automatic go_run;
        do_reset();
        vdd_on = 1;
        step(1 + HOLD);
        chk("R2 hold auto", a_code, 1);
        chk("R2 hold latched", l_code, 1);
        step(1);
        chk("R2 run auto", a_code, 2);
        chk("R2 sw_en auto", a_en, 1);
        chk("R2 run latched", l_code, 2);
        vdd_on = 0;
    endtask

    // Recovery-group fault selector: 0 sec_ovp, 1 vdd_ovp, 2 wind, 3 aux.
    task automatic set_rf(input int k, input logic v);
        case (k)
            0: sovp = v;
            1: vovp = v;
            2: begin wind = v; leb = v; end
            default: aux = v;
        endcase
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset();
        chk("R1 code auto", a_code, 0);
        chk("R1 code latched", l_code, 0);
        chk("R1 sw_en", a_en, 0);
        chk("R1 fault_supply", a_flt, 0);
        step(4);
        chk("R2 idle without on-level", a_code, 0);

        // R2 start hold then run
        go_run();

        // R3 discharge group sweep
        for (int k = 0; k < 2; k++) begin
            go_run();
            if (k == 0) tsd = 1; else cs_sh = 1;
            step(1);
            tsd = 0; cs_sh = 0;
            chk("R3 disch auto", a_code, 3);
            chk("R3 disch latched", l_code, 3);
            chk("R3 sw_en off", a_en, 0);
            step(3);
            chk("R3 waits for off-level", a_code, 3);
            vdd_off = 1;
            step(1);
            chk("R3 exit to reset", a_code, 0);
        end

        // R4 brown-out persistence, R5 direct restart
        go_run();
        line_low = 1;
        step(BO - 1);
        chk("R4 short burst ignored", a_code, 2);
        line_low = 0;
        step(1);
        line_low = 1;
        step(BO);
        chk("R4 filter not yet acted", a_code, 2);
        step(1);
        chk("R4 brown-out discharge", a_code, 3);
        step(2);
        line_low = 0;
        step(1);
        chk("R5 still discharging", a_code, 3);
        step(1);
        chk("R5 direct restart auto", a_code, 1);
        chk("R5 direct restart latched", l_code, 1);

        // R6/R7/R8 recovery group sweep with build-dependent expectations
        for (int k = 0; k < 4; k++) begin
            int exp_l;
            exp_l = (k >= 2) ? 5 : 4;
            go_run();
            set_rf(k, 1);
            step(1);
            set_rf(k, 0);
            chk("R8 auto recovery", a_code, 4);
            chk("R6 fault_supply", a_flt, 1);
            chk("R7 latched group", l_code, exp_l);
            vdd_on = 1;
            step(REC);
            chk("R6 timer running", a_code, 4);
            step(1);
            chk("R6 restart auto", a_code, 1);
            chk("R7 latched sort", l_code, (k >= 2) ? 5 : 1);
            if (k >= 2) begin
                vdd_on = 0;
                vdd_off = 1;
                step(2);
                chk("R7 off-level ignored", l_code, 5);
                vdd_rst = 1;
                step(1);
                chk("R7 release at reset level", l_code, 0);
            end
        end

        // R6 restart needs on-level after expiry
        go_run();
        sovp = 1;
        step(1);
        sovp = 0;
        step(REC + 3);
        chk("R6 waits for on-level", a_code, 4);
        chk("R6 waits latched", l_code, 4);
        vdd_on = 1;
        step(1);
        chk("R6 restart on-level", a_code, 1);

        // R8 over-temperature needs temp_ok in auto build
        go_run();
        otp = 1;
        step(1);
        otp = 0;
        chk("R8 otp auto", a_code, 4);
        chk("R7 otp latched", l_code, 5);
        vdd_on = 1;
        step(REC + 3);
        chk("R8 waits temp_ok", a_code, 4);
        tok = 1;
        step(1);
        chk("R8 restart temp_ok", a_code, 1);

        // R9 winding short gated by blanking window
        go_run();
        wind = 1;
        step(3);
        chk("R9 ignored auto", a_code, 2);
        chk("R9 ignored latched", l_code, 2);
        leb = 1;
        step(1);
        chk("R9 gated auto", a_code, 4);
        chk("R9 gated latched", l_code, 5);

        // R10 priority across groups
        go_run();
        tsd = 1; sovp = 1;
        step(1);
        chk("R10 recov over disch auto", a_code, 4);
        chk("R10 recov over disch latched", l_code, 4);
        go_run();
        tsd = 1; sovp = 1; aux = 1;
        step(1);
        chk("R10 three groups auto", a_code, 4);
        chk("R10 latch wins latched", l_code, 5);

        // R11 reset level from run and from recovery
        go_run();
        vdd_rst = 1;
        step(1);
        chk("R11 from run", a_code, 0);
        go_run();
        vovp = 1;
        step(1);
        vovp = 0;
        vdd_rst = 1;
        step(1);
        chk("R11 from recovery", a_code, 0);

        // R12 off-level in start hold and run
        do_reset();
        vdd_on = 1;
        step(1);
        chk("R12 in hold", a_code, 1);
        vdd_off = 1;
        step(1);
        chk("R12 hold to reset", a_code, 0);
        go_run();
        vdd_off = 1;
        step(1);
        chk("R12 run to reset", a_code, 0);
        chk("R12 run to reset latched", l_code, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule